// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on into a usable state. It waits for a one-time configuration write. The write carries the read latency, the row-active time, the precharge time, an order bit and an enable bit. Once the write is accepted with enable set, the block issues the start-up commands on the SDRAM command pins exactly once. First comes a precharge of all banks. Then come eight auto-refresh commands and one mode-register load, in the order the order bit selects.

Until the sequence has finished, the block holds off user accesses: its acknowledge output stays low. After the sequence, the data-mask lines drop, a sticky done flag rises, and every access request is acknowledged.

In a shared-memory cluster, only the device whose identifier is zero drives the mode-register load. Every other device leaves that slot idle but keeps the same timing, so all devices become ready in the same cycle.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and until an enabled configuration is accepted, the pins are held at fixed idle levels: sd_cke=1; sd_cs_n, sd_ras_n, sd_cas_n and sd_we_n all 1; both sd_dqm lines 1; sd_a10=1; sd_addr=0. init_done and acc_ack are 0 during this time.
- R2: The sequence starts on the clock edge that accepts an enabled configuration. Its first command, visible in the next cycle, is precharge-all: (cs_n,ras_n,cas_n,we_n)=(0,0,1,0) with sd_a10=1. That command lasts one cycle. The next command appears exactly tRP cycles after it.
- R3: Exactly eight auto-refresh commands are issued. Each is (0,0,0,1) with sd_a10=1 and sd_addr=0. Each refresh starts a slot of tRAS+tRP cycles.
- R4: The mode-register load is (0,0,0,0) with sd_a10=0. Its address word is: sd_addr[2:0]=3'b111 (full-page burst), sd_addr[3]=0 (sequential), sd_addr[6:4]=CAS latency, and sd_addr[13:7]=0. It starts a slot of 2 cycles.
- R5: With cfg_order=0, the commands run precharge, eight refreshes, then the mode load. With cfg_order=1, they run precharge, the mode load, then eight refreshes.
- R6: Call the precharge cycle P. init_done rises in cycle P + tRP + 8*(tRAS+tRP) + 2. From that cycle on, the bus is idle (sd_cs_n=1, ras/cas/we 1) with both sd_dqm=0, sd_a10=0 and sd_addr=0. Every cycle between commands carries the idle pattern with sd_dqm=1 and sd_a10=1.
- R7: When dev_id is nonzero, the mode-load slot carries the idle pattern instead of the mode-load command. All slot lengths, and the cycle in which init_done rises, are unchanged.
- R8: acc_ack equals acc_req AND init_done in every cycle, so no access is acknowledged before the sequence ends.
- R9: A configuration write is legal only when CAS latency is 1 to 3, tRAS is 2 to 8, and tRP is 2 to 5. Writes that are not legal are ignored. The first legal write is taken and every later write is ignored. If that first legal write has enable=0, the block stays idle until reset.
- R10: init_done stays high until reset, and the sequence never runs a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Enable bit of the configuration |
| cfg_order | input | 1 | 0: refreshes before mode load; 1: mode load first |
| cfg_cas_lat | input | 2 | Read latency in cycles (1..3) |
| cfg_tras | input | 4 | Row-active time in cycles (2..8) |
| cfg_trp | input | 3 | Precharge time in cycles (2..5) |
| dev_id | input | 3 | Cluster identifier; 0 drives the mode load |
| acc_req | input | 1 | User access request |
| acc_ack | output | 1 | Access acknowledge |
| init_done | output | 1 | Sticky start-up complete flag |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 2 | Data-mask lines (high and low lane) |
| sd_a10 | output | 1 | All-bank select line |
| sd_addr | output | 14 | SDRAM address / mode word |

## Verification
The sequence is tried with four configurations:
- Refresh-first order with mid-range timings, which fixes the baseline slot lengths and the latency field in the mode word.
- Mode-first order with the largest timings, which exposes any mix-up in the order and any slot counter that is too narrow.
- A nonzero identifier with the smallest timings, which separates "skip the command" from "skip the slot".
- A first legal write with enable clear, which shows that the once-only lock is kept apart from the start trigger.

Illegal writes, and writes made during and after the sequence, show whether a second write can alter timing or restart it. A toggling request line shows that acknowledge is gated by the done flag alone.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;
  localparam int CL_W   = 2;
  localparam int TRAS_W = 4;
  localparam int TRP_W  = 3;
  localparam int SLOT_W = 4;
  localparam int MODE_W = 14;

  typedef enum logic [2:0] {
    CMD_IDLE, CMD_NOP, CMD_PREA, CMD_REF, CMD_MRS, CMD_READY
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_REF, ST_MRS, ST_DONE
  } st_e;

  typedef struct packed {
    logic              order;
    logic [CL_W-1:0]   cl;
    logic [TRAS_W-1:0] tras;
    logic [TRP_W-1:0]  trp;
  } cfg_t;

  function automatic logic cfg_legal(cfg_t c);
    return (c.cl != '0) && (c.tras >= 4'd2) && (c.tras <= 4'd8) &&
           (c.trp >= 3'd2) && (c.trp <= 3'd5);
  endfunction

  // slot lengths minus one, loaded into the down-counter
  function automatic logic [SLOT_W-1:0] prea_last(cfg_t c);
    return SLOT_W'(c.trp) - SLOT_W'(1);
  endfunction

  function automatic logic [SLOT_W-1:0] ref_last(cfg_t c);
    return SLOT_W'(c.tras) + SLOT_W'(c.trp) - SLOT_W'(1);
  endfunction

  function automatic logic [MODE_W-1:0] mode_word(logic [CL_W-1:0] cl);
    logic [MODE_W-1:0] w;
    w      = '0;
    w[2:0] = 3'b111;
    w[3]   = 1'b0;
    w[6:4] = {1'b0, cl};
    return w;
  endfunction

  function automatic st_e next_slot(st_e cur, logic order, logic refs_left);
    st_e n;
    case (cur)
      ST_PRE:  n = order ? ST_MRS : ST_REF;
      ST_REF:  n = refs_left ? ST_REF : (order ? ST_DONE : ST_MRS);
      ST_MRS:  n = order ? ST_REF : ST_DONE;
      default: n = cur;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/sdinit_cfg.sv
module sdinit_cfg
  import sdinit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic enable,
  input  cfg_t cfg_in,
  output cfg_t cfg_eff,
  output logic start,
  output logic locked
);
  cfg_t stored_q;
  logic locked_q;
  logic accept;

  assign accept  = wr && !locked_q && cfg_legal(cfg_in);
  assign start   = accept && enable;
  assign cfg_eff = accept ? cfg_in : stored_q;
  assign locked  = locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      stored_q <= '0;
    end else if (accept) begin
      locked_q <= 1'b1;
      stored_q <= cfg_in;
    end
  end
endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int REF_BURST = 8,
  parameter int MRD_CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  cfg_t cfg,
  input  logic is_master,
  output cmd_e cmd_nxt,
  output logic done,
  output logic slot_adv
);
  localparam int CNT_W = $clog2(REF_BURST + 1);
  localparam logic [CNT_W-1:0] REF_LAST = CNT_W'(REF_BURST);
  localparam logic [SLOT_W-1:0] MRD_LAST = SLOT_W'(MRD_CYC - 1);

  st_e               st_q, st_d;
  logic [SLOT_W-1:0] tmr_q, tmr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              refs_left;
  st_e               tgt;

  assign refs_left = (cnt_q != REF_LAST);
  assign tgt       = next_slot(st_q, cfg.order, refs_left);
  assign done      = (st_q == ST_DONE);

  always_comb begin
    st_d     = st_q;
    tmr_d    = tmr_q;
    cnt_d    = cnt_q;
    slot_adv = 1'b0;
    cmd_nxt  = CMD_NOP;
    case (st_q)
      ST_IDLE: begin
        cmd_nxt = CMD_IDLE;
        if (start) begin
          st_d    = ST_PRE;
          tmr_d   = prea_last(cfg);
          cmd_nxt = CMD_PREA;
        end
      end
      ST_DONE: cmd_nxt = CMD_READY;
      default: begin
        if (tmr_q != '0) begin
          tmr_d = tmr_q - SLOT_W'(1);
        end else begin
          slot_adv = 1'b1;
          st_d     = tgt;
          case (tgt)
            ST_REF: begin
              tmr_d   = ref_last(cfg);
              cnt_d   = cnt_q + CNT_W'(1);
              cmd_nxt = CMD_REF;
            end
            ST_MRS: begin
              tmr_d   = MRD_LAST;
              cmd_nxt = is_master ? CMD_MRS : CMD_NOP;
            end
            default: cmd_nxt = CMD_READY;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sdinit_pins.sv
module sdinit_pins
  import sdinit_pkg::*;
#(
  parameter int DQM_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_e                 cmd_nxt,
  input  logic [CL_W-1:0]      cl,
  output logic                 cke,
  output logic                 cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [DQM_LANES-1:0] dqm,
  output logic                 a10,
  output logic [MODE_W-1:0]    addr
);
  logic [3:0]        pat_d;
  logic              a10_d;
  logic              mask_d;
  logic [MODE_W-1:0] addr_d;
  logic              mask_q;

  always_comb begin
    pat_d  = 4'b1111;
    a10_d  = 1'b1;
    mask_d = 1'b1;
    addr_d = '0;
    case (cmd_nxt)
      CMD_PREA: pat_d = 4'b0010;
      CMD_REF:  pat_d = 4'b0001;
      CMD_MRS: begin
        pat_d  = 4'b0000;
        a10_d  = 1'b0;
        addr_d = mode_word(cl);
      end
      CMD_READY: begin
        a10_d  = 1'b0;
        mask_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke                      <= 1'b1;
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      a10                      <= 1'b1;
      addr                     <= '0;
      mask_q                   <= 1'b1;
    end else begin
      cke                      <= 1'b1;
      {cs_n, ras_n, cas_n, we_n} <= pat_d;
      a10                      <= a10_d;
      addr                     <= addr_d;
      mask_q                   <= mask_d;
    end
  end

  for (genvar g = 0; g < DQM_LANES; g++) begin : g_lane
    assign dqm[g] = mask_q;
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int REF_BURST = 8,
  parameter int MRD_CYC   = 2,
  parameter int ID_W      = 3,
  parameter int DQM_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_enable,
  input  logic                 cfg_order,
  input  logic [CL_W-1:0]      cfg_cas_lat,
  input  logic [TRAS_W-1:0]    cfg_tras,
  input  logic [TRP_W-1:0]     cfg_trp,
  input  logic [ID_W-1:0]      dev_id,
  input  logic                 acc_req,
  output logic                 acc_ack,
  output logic                 init_done,
  output logic                 sd_cke,
  output logic                 sd_cs_n,
  output logic                 sd_ras_n,
  output logic                 sd_cas_n,
  output logic                 sd_we_n,
  output logic [DQM_LANES-1:0] sd_dqm,
  output logic                 sd_a10,
  output logic [MODE_W-1:0]    sd_addr
);
  cfg_t cfg_in, cfg_eff;
  logic seq_start, cfg_locked, is_master, slot_adv;
  cmd_e cmd_nxt;

  assign cfg_in    = '{order: cfg_order, cl: cfg_cas_lat, tras: cfg_tras, trp: cfg_trp};
  assign is_master = (dev_id == '0);

  sdinit_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .enable(cfg_enable),
    .cfg_in(cfg_in), .cfg_eff(cfg_eff), .start(seq_start), .locked(cfg_locked)
  );

  sdinit_seq #(.REF_BURST(REF_BURST), .MRD_CYC(MRD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .cfg(cfg_eff),
    .is_master(is_master), .cmd_nxt(cmd_nxt), .done(init_done), .slot_adv(slot_adv)
  );

  sdinit_pins #(.DQM_LANES(DQM_LANES)) u_pins (
    .clk(clk), .rst_n(rst_n), .cmd_nxt(cmd_nxt), .cl(cfg_eff.cl),
    .cke(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n),
    .we_n(sd_we_n), .dqm(sd_dqm), .a10(sd_a10), .addr(sd_addr)
  );

  assign acc_ack = acc_req && init_done;
endmodule

// File: rtl/sdinit_chk.sv
module sdinit_chk #(
  parameter int REF_BURST = 8,
  parameter int ID_W      = 3,
  parameter int DQM_LANES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ID_W-1:0]      dev_id,
  input logic                 acc_ack,
  input logic                 init_done,
  input logic                 sd_cs_n,
  input logic                 sd_ras_n,
  input logic                 sd_cas_n,
  input logic                 sd_we_n,
  input logic [DQM_LANES-1:0] sd_dqm,
  input logic                 sd_a10,
  input logic [13:0]          sd_addr
);
  logic [3:0] pat;
  logic       is_prea, is_ref, is_mrs, started_q;
  logic [7:0] ref_seen_q;

  assign pat     = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_prea = (pat == 4'b0010);
  assign is_ref  = (pat == 4'b0001);
  assign is_mrs  = (pat == 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q  <= 1'b0;
      ref_seen_q <= '0;
    end else begin
      if (!sd_cs_n) started_q <= 1'b1;
      if (is_ref && ref_seen_q != 8'hFF) ref_seen_q <= ref_seen_q + 8'd1;
    end
  end

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (!started_q && sd_cs_n) |-> (pat == 4'b1111 && sd_a10 && (&sd_dqm) && !init_done)); // R1
  AST_FIRST_IS_PREA: assert property (@(posedge clk) disable iff (!rst_n)
    (!started_q && !sd_cs_n) |-> (is_prea && sd_a10)); // R2
  AST_REF_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (sd_a10 && sd_addr == '0)); // R3
  AST_REF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_seen_q <= 8'(REF_BURST)); // R3
  AST_MRS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (sd_addr[3:0] == 4'b0111 && sd_addr[13:7] == '0 &&
                sd_addr[6:4] != 3'd0 && sd_addr[6:4] <= 3'd3 && !sd_a10)); // R4
  AST_MRS_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (dev_id == '0)); // R7
  AST_DONE_AFTER_REFS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (ref_seen_q == 8'(REF_BURST))); // R6
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (sd_cs_n && sd_dqm == '0)); // R6
  AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |-> init_done); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R10
endmodule

bind sdram_init_seq sdinit_chk #(.REF_BURST(REF_BURST), .ID_W(ID_W), .DQM_LANES(DQM_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .acc_ack(acc_ack), .init_done(init_done),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_dqm(sd_dqm), .sd_a10(sd_a10), .sd_addr(sd_addr)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_enable = 1'b0, cfg_order = 1'b0;
  logic [1:0] cfg_cas_lat = 2'd0;
  logic [3:0] cfg_tras = 4'd0;
  logic [2:0] cfg_trp = 3'd0;
  logic [2:0] dev_id = 3'd0;
  logic acc_req = 1'b0;
  logic acc_ack, init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;
  logic [1:0] sd_dqm;
  logic [13:0] sd_addr;

  always #2 clk = ~clk;

  sdram_init_seq u_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
    .cfg_order(cfg_order), .cfg_cas_lat(cfg_cas_lat), .cfg_tras(cfg_tras),
    .cfg_trp(cfg_trp), .dev_id(dev_id), .acc_req(acc_req), .acc_ack(acc_ack),
    .init_done(init_done), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_a10(sd_a10),
    .sd_addr(sd_addr)
  );

  // codes: 0 idle, 1 gap, 2 precharge, 3 refresh, 4 mode load, 5 ready
  int   q[$];
  bit   m_locked, m_started;
  int   m_cl;
  int   n_vec = 0, n_bad = 0, cyc = 0;
  int   t_prea, t_done, obs_ref, obs_mrs, refs_before_mrs, obs_cmd;

  function automatic logic [21:0] expect_pins(int code, int cl);
    logic [13:0] mw;
    mw = 14'(cl * 16 + 7);
    case (code)
      2:       return {1'b1, 4'b0010, 2'b11, 1'b1, 14'd0};
      3:       return {1'b1, 4'b0001, 2'b11, 1'b1, 14'd0};
      4:       return {1'b1, 4'b0000, 2'b11, 1'b0, mw};
      5:       return {1'b1, 4'b1111, 2'b00, 1'b0, 14'd0};
      default: return {1'b1, 4'b1111, 2'b11, 1'b1, 14'd0};
    endcase
  endfunction

  function automatic string tag_of(int code);
    case (code)
      0: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // reference model: builds the full command timeline when a write is taken (R5, R7, R9)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_locked = 0; m_started = 0; m_cl = 0; q.delete();
    end else if (cfg_wr && !m_locked && cfg_cas_lat >= 1 && cfg_cas_lat <= 3 &&
                 cfg_tras >= 2 && cfg_tras <= 8 && cfg_trp >= 2 && cfg_trp <= 5) begin
      m_locked = 1;
      if (cfg_enable) begin
        m_started = 1;
        m_cl = int'(cfg_cas_lat);
        q.push_back(2);
        for (int i = 1; i < int'(cfg_trp); i++) q.push_back(1);
        if (cfg_order) begin
          q.push_back(dev_id == 0 ? 4 : 1); q.push_back(1);
        end
        for (int r = 0; r < 8; r++) begin
          q.push_back(3);
          for (int i = 1; i < int'(cfg_tras) + int'(cfg_trp); i++) q.push_back(1);
        end
        if (!cfg_order) begin
          q.push_back(dev_id == 0 ? 4 : 1); q.push_back(1);
        end
      end
    end
  end

  // per-cycle compare, away from the active edge
  always @(negedge clk) begin
    int code;
    logic [21:0] act, exp;
    cyc++;
    code = !m_started ? 0 : (q.size() > 0 ? q.pop_front() : 5);
    exp  = expect_pins(code, m_cl);
    act  = {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_a10, sd_addr};
    check(act == exp, tag_of(code), "pins", int'(act), int'(exp));
    check(init_done == (code == 5), "R6", "init_done", int'(init_done), int'(code == 5));
    check(acc_ack == (acc_req && code == 5), "R8", "acc_ack", int'(acc_ack), int'(acc_req && code == 5));
    if (!sd_cs_n) obs_cmd++;
    if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010 && t_prea < 0) t_prea = cyc;
    if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001) obs_ref++;
    if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000) begin
      obs_mrs++; refs_before_mrs = obs_ref;
    end
    if (init_done && t_done < 0) t_done = cyc;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      summary();
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk); #1;
      acc_req = ((cyc % 3) != 0);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0;
    t_prea = -1; t_done = -1; obs_ref = 0; obs_mrs = 0; refs_before_mrs = -1; obs_cmd = 0;
    step(3);
    rst_n = 1;
    step(2);
  endtask

  task automatic write_cfg(bit en, bit ord, int cl, int tras, int trp);
    cfg_enable = en; cfg_order = ord;
    cfg_cas_lat = 2'(cl); cfg_tras = 4'(tras); cfg_trp = 3'(trp);
    cfg_wr = 1;
    step(1);
    cfg_wr = 0;
  endtask

  initial begin
    // refresh-first order, mid timings, illegal write first (R9), rewrite after done (R10)
    dev_id = 0;
    do_reset();
    check(sd_cs_n && sd_dqm == 2'b11 && sd_a10 && !init_done, "R1", "reset levels", int'(sd_cs_n), 1);
    write_cfg(1, 0, 0, 4, 3);
    step(5);
    check(t_prea < 0, "R9", "illegal write started sequence", t_prea, -1);
    write_cfg(1, 0, 2, 4, 3);
    step(80);
    check(t_done - t_prea == 3 + 8 * 7 + 2, "R6", "duration", t_done - t_prea, 61);
    check(refs_before_mrs == 8, "R5", "refs before mode load (order 0)", refs_before_mrs, 8);
    check(obs_mrs == 1, "R4", "mode load count", obs_mrs, 1);
    write_cfg(1, 1, 3, 8, 5);
    step(30);
    check(init_done && obs_ref == 8, "R10", "no rerun after done", obs_ref, 8);

    // mode-first order, largest timings, write during the sequence
    do_reset();
    write_cfg(1, 1, 3, 8, 5);
    step(20);
    write_cfg(1, 0, 1, 2, 2);
    step(120);
    check(t_done - t_prea == 5 + 8 * 13 + 2, "R6", "duration max", t_done - t_prea, 111);
    check(refs_before_mrs == 0, "R5", "refs before mode load (order 1)", refs_before_mrs, 0);
    check(obs_ref == 8, "R3", "refresh count", obs_ref, 8);

    // nonzero identifier, smallest timings
    dev_id = 5;
    do_reset();
    write_cfg(1, 0, 1, 2, 2);
    step(50);
    check(obs_mrs == 0, "R7", "mode load from non-master", obs_mrs, 0);
    check(t_done - t_prea == 2 + 8 * 4 + 2, "R7", "duration non-master", t_done - t_prea, 36);

    // first legal write with enable clear locks the configuration
    dev_id = 0;
    do_reset();
    write_cfg(0, 0, 2, 4, 3);
    step(5);
    write_cfg(1, 0, 2, 4, 3);
    step(80);
    check(!init_done && obs_cmd == 0, "R9", "locked without enable", obs_cmd, 0);

    summary();
  end
endmodule